// File: doc/BRIEF.md
# Infrared receive pulse demodulator

This block sits between a raw infrared receive pin and a UART receiver. An infrared link marks a zero bit with a short low pulse instead of holding the line low for the whole bit. The block measures each low pulse with a down counter that runs on the system clock. A pulse that stays low long enough is accepted, and the receiver input is then held low for one full bit period. A pulse that ends too early is treated as noise, and the receiver input stays high.

The filter length and the bit period are inputs. The filter length is the reload value of the counter. The bit period is a count of system clocks. The raw pin is synchronized inside the block. The output idles high, which is the UART idle level.

Top module: `irda_rx_demod`

## Requirements
- R1: After reset, and whenever no accepted pulse is being stretched, `rxd_filt` is high. Asserting reset while a bit is being stretched forces `rxd_filt` high at once.
- R2: `rxd_raw` passes through a two-flop synchronizer. When `rxd_raw` first samples low on clock edge 1, an accepted pulse drives `rxd_filt` low from the edge numbered `filt_val` + 3 onward.
- R3: A raw low pulse lasting at least `filt_val` + 1 clock cycles is accepted. The counter is loaded with `filt_val` on the falling edge and decrements once per clock, and the pulse is accepted when the count reaches zero before a rising edge arrives.
- R4: A raw low pulse lasting `filt_val` cycles or fewer is rejected. The rising edge reloads the counter, and `rxd_filt` stays high.
- R5: An accepted pulse holds `rxd_filt` low for exactly `bit_len` clock cycles, as one contiguous low period. A `bit_len` of 0 is treated as 1.
- R6: Falling edges on the raw input that arrive while a bit is being stretched are ignored. They neither lengthen the low period nor start a second one.
- R7: With `filt_val` equal to 0, every falling edge is accepted on the clock after it is detected, even for a one-cycle pulse.
- R8: A raw input that is held low past the end of the stretched bit produces only one low period. A new bit needs a rising edge followed by a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_raw | input | 1 | Raw infrared receive input, asynchronous |
| filt_val | input | FILT_W (8) | Counter reload value that sets the minimum pulse length |
| bit_len | input | BIT_W (16) | Length of one bit period, in system clocks |
| rxd_filt | output | 1 | Filtered receiver input, idles high |

## Verification
The hardest cases to reach are those that depend on one clock of timing. One is a pulse whose length equals `filt_val` or `filt_val` + 1, where a single cycle decides between rejection and acceptance. The other is a second falling edge that lands inside a bit already being stretched. The stimulus drives the raw pin cycle by cycle and places both pulse lengths on each side of the threshold, including the largest reload value. It also places a second pulse at a fixed offset so that its synchronized falling edge falls inside the low period. Random pulse lengths, reload values and bit periods cover the remaining cases. Each run's low-cycle count, its number of low periods and its start offset are compared with the values the requirements predict.

// File: rtl/irda_rx_demod.sv
module irda_rx_demod #(
  parameter int FILT_W = 8,
  parameter int BIT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_raw,
  input  logic [FILT_W-1:0] filt_val,
  input  logic [BIT_W-1:0]  bit_len,
  output logic              rxd_filt
);

  logic [2:0]        sync_q;
  logic              counting;
  logic              active;
  logic [FILT_W-1:0] cnt;
  logic [BIT_W-1:0]  tmr;

  wire fall   = sync_q[2] & ~sync_q[1];
  wire rise   = ~sync_q[2] & sync_q[1];
  wire accept = (counting && !rise && cnt == FILT_W'(1)) ||
                (!counting && !active && fall && filt_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      counting <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      tmr      <= '0;
    end else begin
      sync_q <= {sync_q[1:0], rxd_raw};
      if (active) begin
        if (tmr == '0) active <= 1'b0;
        else           tmr    <= tmr - BIT_W'(1);
      end else if (accept) begin
        active   <= 1'b1;
        counting <= 1'b0;
        cnt      <= '0;
        tmr      <= (bit_len == '0) ? '0 : bit_len - BIT_W'(1);
      end else if (counting) begin
        if (rise) begin
          counting <= 1'b0;
          cnt      <= filt_val;
        end else begin
          cnt <= cnt - FILT_W'(1);
        end
      end else if (fall) begin
        counting <= 1'b1;
        cnt      <= filt_val;
      end
    end
  end

  assign rxd_filt = ~active;

endmodule

// File: rtl/irda_rx_demod_chk.sv
module irda_rx_demod_chk #(
  parameter int FILT_W = 8,
  parameter int BIT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxd_filt,
  input logic              rx_sync,
  input logic              counting,
  input logic [FILT_W-1:0] cnt,
  input logic [FILT_W-1:0] filt_val,
  input logic [BIT_W-1:0]  bit_len
);

  logic [BIT_W:0] lowrun;
  wire  [BIT_W:0] exp_len = (bit_len == '0) ? (BIT_W+1)'(1) : {1'b0, bit_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowrun <= '0;
    else if (rxd_filt) lowrun <= '0;
    else               lowrun <= lowrun + (BIT_W+1)'(1);
  end

  AST_RESET_HIGH: assert property (@(posedge clk) !rst_n |-> rxd_filt);  // R1
  AST_ACCEPT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd_filt) |-> !$past(rx_sync));  // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (cnt != '0 && cnt <= filt_val));  // R4
  AST_BIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_filt) |-> lowrun == exp_len);  // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_filt |-> !counting);  // R6

endmodule

bind irda_rx_demod irda_rx_demod_chk #(.FILT_W(FILT_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxd_filt(rxd_filt), .rx_sync(sync_q[1]),
  .counting(counting), .cnt(cnt), .filt_val(filt_val), .bit_len(bit_len)
);

// File: tb/irda_rx_demod_test.sv
module irda_rx_demod_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd_raw = 1'b1;
  logic [7:0]  filt_val = 8'd3;
  logic [15:0] bit_len = 16'd8;
  logic        rxd_filt;
  int total = 0;
  int bad = 0;
  bit done = 0;

  irda_rx_demod uut (.clk(clk), .rst_n(rst_n), .rxd_raw(rxd_raw),
    .filt_val(filt_val), .bit_len(bit_len), .rxd_filt(rxd_filt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_accept(input int n, input int l);
    return l >= n + 1;
  endfunction

  function automatic int exp_lows(input int n, input int l, input int b);
    return exp_accept(n, l) ? ((b == 0) ? 1 : b) : 0;
  endfunction

  task automatic run_pulse(input int n, input int l, input int b, input int j2,
                           input int l2, input string tag);
    int first = -1, lows = 0, falls = 0, w;
    bit prv = 1, cur;
    filt_val = 8'(n);
    bit_len  = 16'(b);
    repeat (4) @(negedge clk);
    rxd_raw = 1'b0;
    w = n + 3 + ((b > l) ? b : l) + ((j2 > 0) ? j2 + l2 : 0) + 6;
    for (int i = 1; i <= w; i++) begin
      @(posedge clk);
      @(negedge clk);
      cur = rxd_filt;
      if (!cur) lows++;
      if (!cur && prv) begin
        falls++;
        if (first < 0) first = i;
      end
      prv = cur;
      rxd_raw = ((i < l) || (j2 > 0 && i >= j2 && i < j2 + l2)) ? 1'b0 : 1'b1;
    end
    chk(falls == int'(exp_accept(n, l)), {tag, " periods"}, falls, int'(exp_accept(n, l)));
    chk(lows == exp_lows(n, l, b), {tag, " low cycles"}, lows, exp_lows(n, l, b));
    if (exp_accept(n, l)) chk(first == n + 3, {tag, " R2 latency"}, first, n + 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rxd_filt == 1'b1, "R1 reset high", rxd_filt, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rxd_filt == 1'b1, "R1 idle high", rxd_filt, 1);

    run_pulse(3, 4, 8, 0, 0, "R3 threshold accept");
    run_pulse(3, 3, 8, 0, 0, "R4 threshold reject");
    run_pulse(5, 1, 8, 0, 0, "R4 glitch reject");
    run_pulse(255, 256, 4, 0, 0, "R3 max filter accept");
    run_pulse(255, 255, 4, 0, 0, "R4 max filter reject");
    run_pulse(0, 1, 6, 0, 0, "R7 zero filter");
    run_pulse(2, 3, 0, 0, 0, "R5 zero bit length");
    run_pulse(2, 4, 20, 10, 5, "R6 fall during bit");
    run_pulse(1, 40, 8, 0, 0, "R8 long low");

    for (int k = 0; k < 40; k++) begin
      int n = int'($urandom_range(0, 12));
      int l = int'($urandom_range(1, 16));
      int b = int'($urandom_range(1, 40));
      run_pulse(n, l, b, 0, 0, "R3 R4 R5 random");
    end

    filt_val = 8'd1;
    bit_len = 16'd50;
    @(negedge clk);
    rxd_raw = 1'b0;
    repeat (10) @(negedge clk);
    rxd_raw = 1'b1;
    chk(rxd_filt == 1'b0, "R5 stretching before reset", rxd_filt, 0);
    rst_n = 1'b0;
    #1;
    chk(rxd_filt == 1'b1, "R1 reset during bit", rxd_filt, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rxd_filt == 1'b1, "R1 high after reset", rxd_filt, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule